// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Slot-Directed Fill

This block is a small, fully associative address translation buffer. Every slot holds a virtual page tag, a partition number, an address-space context, a flag for real (untranslated) accesses, a two-bit page-size code, a physical page base, and valid and used bits. A lookup compares the request against all slots at once. On a hit it returns the physical address, formed from the slot's page base and the request's offset within the page. The entry's used bit is also updated.

New entries come in through an insert stream. The caller either names the slot to fill or leaves the choice to the block. In that case a not-recently-used policy picks the slot. When no slot qualifies, the last slot is taken. A single-cycle invalidate input empties the whole table. Both request streams use valid/ready. An insert transfers when `ins_valid_i` and `ins_ready_o` are both high on a clock edge. A lookup transfers when `lkp_valid_i` and `lkp_ready_o` are both high. The requester must hold its valid signal and payload steady until the transfer happens. The response is a one-deep register. A response that is not accepted (`rsp_ready_i` low) stays unchanged and blocks further lookups until it is taken.

Top module: `fa_tlb`

## Requirements
- R1: After reset, or in the cycle after `flush_i` is high, no slot is valid and every lookup misses. While `flush_i` is high, `ins_ready_o` and `lkp_ready_o` are both low.
- R2: An insert with `ins_use_idx_i` = 1 writes the entry into slot `ins_idx_i` (which must be below ENTRIES), replacing whatever was there. The new entry starts with its used bit set.
- R3: An insert with `ins_use_idx_i` = 0 fills the lowest-numbered slot that is invalid or has its used bit clear. The new entry starts with its used bit clear.
- R4: When no slot is invalid and every used bit is set, a slot-free insert overwrites slot ENTRIES-1.
- R5: A lookup hits a slot only when all of the following hold: the slot is valid; the partition, context and real flag are equal to the request's; and the virtual address bits above the slot's page offset are equal to the request's.
- R6: Size code 0 selects a 13-bit page offset, 1 a 16-bit offset, 2 a 22-bit offset and 3 a 28-bit offset. The offset bits are excluded from the tag compare.
- R7: The hit address is the slot's physical base with its offset bits cleared, ORed with the request's offset bits. On a miss `rsp_pa_o` is zero. When several slots hit, the lowest-numbered one supplies the result.
- R8: A hit on a slot whose used bit is clear sets that bit. If that would leave every used bit set, all the other used bits are cleared instead. A hit on an already-used slot changes no used bit.
- R9: A lookup accepted at a clock edge presents `rsp_valid_o`, `rsp_hit_o` and `rsp_pa_o` right after that edge. An insert accepted at an edge is visible to a lookup accepted at the next edge.
- R10: An insert takes precedence over a lookup, so `lkp_ready_o` is low while `ins_valid_i` is high. `lkp_ready_o` is also low while a response is waiting with `rsp_ready_i` low, and the waiting response stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate every slot |
| ins_valid_i | input | 1 | Insert request valid |
| ins_ready_o | output | 1 | Insert can be taken |
| ins_use_idx_i | input | 1 | Use `ins_idx_i` instead of victim search |
| ins_idx_i | input | IW (3) | Caller-named slot |
| ins_va_i | input | VA_W (40) | Virtual address of the page |
| ins_pid_i | input | PID_W (3) | Partition number |
| ins_ctx_i | input | CTX_W (13) | Context number |
| ins_rmode_i | input | 1 | Entry serves real-mode accesses |
| ins_size_i | input | 2 | Page-size code |
| ins_pa_i | input | PA_W (36) | Physical page base |
| lkp_valid_i | input | 1 | Lookup request valid |
| lkp_ready_o | output | 1 | Lookup can be taken |
| lkp_va_i | input | VA_W (40) | Virtual address to translate |
| lkp_pid_i | input | PID_W (3) | Partition number of the access |
| lkp_ctx_i | input | CTX_W (13) | Context of the access |
| lkp_rmode_i | input | 1 | Access is real-mode |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_pa_o | output | PA_W (36) | Translated physical address |

## Verification
The checks assume that a caller-named slot index is always below ENTRIES. They also assume that a lookup requester keeps `lkp_valid_i` high until the lookup is accepted. The stimulus reduces every random slot index modulo the table size. Its tasks hold each request until the edge that accepts it. The stimulus drops `rsp_ready_i` only during dedicated back-pressure sequences, and it raises the invalidate input only between complete transactions.

// File: rtl/fa_tlb_pkg.sv
`timescale 1ns/1ps
package fa_tlb_pkg;
  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_4M   = 2'd2,
    PG_256M = 2'd3
  } pg_size_e;

  // Width of the page offset for each size code.
  function automatic int unsigned pg_shift(pg_size_e s);
    case (s)
      PG_8K:   return 13;
      PG_64K:  return 16;
      PG_4M:   return 22;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/fa_tlb_prio.sv
`timescale 1ns/1ps
// Lowest-set-bit finder, shared by victim search and hit selection.
module fa_tlb_prio #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fa_tlb_match.sv
`timescale 1ns/1ps
// Parallel tag compare across all slots, with the offset masked per page size.
module fa_tlb_match
  import fa_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 40,
  parameter int PID_W   = 3,
  parameter int CTX_W   = 13
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VA_W-1:0]    tag_i  [ENTRIES],
  input  logic [PID_W-1:0]   pid_i  [ENTRIES],
  input  logic [CTX_W-1:0]   ctx_i  [ENTRIES],
  input  logic [ENTRIES-1:0] rmode_i,
  input  logic [1:0]         size_i [ENTRIES],
  input  logic [VA_W-1:0]    va_i,
  input  logic [PID_W-1:0]   pid_q_i,
  input  logic [CTX_W-1:0]   ctx_q_i,
  input  logic               rmode_q_i,
  output logic [ENTRIES-1:0] hit_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [VA_W-1:0] keep;
    logic            tag_eq;
    logic            id_eq;
    assign keep   = ~((VA_W'(1) << pg_shift(pg_size_e'(size_i[g]))) - VA_W'(1));
    assign tag_eq = ((tag_i[g] ^ va_i) & keep) == '0;
    assign id_eq  = (pid_i[g] == pid_q_i) && (ctx_i[g] == ctx_q_i) &&
                    (rmode_i[g] == rmode_q_i);
    assign hit_o[g] = valid_i[g] && tag_eq && id_eq;
  end
endmodule

// File: rtl/fa_tlb_used.sv
`timescale 1ns/1ps
// Next-state of the used bits after a lookup hit.
module fa_tlb_used #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  used_i,
  input  logic          hit_i,
  input  logic [IW-1:0] idx_i,
  output logic [N-1:0]  used_o
);
  logic [N-1:0] sel;
  logic [N-1:0] merged;
  logic         bump;

  always_comb begin
    sel    = N'(1) << idx_i;
    merged = used_i | sel;
    bump   = hit_i && ((used_i & sel) == '0);
    if (!bump)
      used_o = used_i;
    else if (&merged)
      used_o = sel;
    else
      used_o = merged;
  end
endmodule

// File: rtl/fa_tlb.sv
`timescale 1ns/1ps
module fa_tlb
  import fa_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 40,
  parameter int PA_W    = 36,
  parameter int PID_W   = 3,
  parameter int CTX_W   = 13,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             ins_valid_i,
  output logic             ins_ready_o,
  input  logic             ins_use_idx_i,
  input  logic [IW-1:0]    ins_idx_i,
  input  logic [VA_W-1:0]  ins_va_i,
  input  logic [PID_W-1:0] ins_pid_i,
  input  logic [CTX_W-1:0] ins_ctx_i,
  input  logic             ins_rmode_i,
  input  logic [1:0]       ins_size_i,
  input  logic [PA_W-1:0]  ins_pa_i,
  input  logic             lkp_valid_i,
  output logic             lkp_ready_o,
  input  logic [VA_W-1:0]  lkp_va_i,
  input  logic [PID_W-1:0] lkp_pid_i,
  input  logic [CTX_W-1:0] lkp_ctx_i,
  input  logic             lkp_rmode_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_hit_o,
  output logic [PA_W-1:0]  rsp_pa_o
);
  // Table state
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] used_q;
  logic [ENTRIES-1:0] rmode_q;
  logic [VA_W-1:0]    tag_q  [ENTRIES];
  logic [PID_W-1:0]   pid_q  [ENTRIES];
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [PA_W-1:0]    pa_q   [ENTRIES];

  // Handshakes: invalidate blocks both streams, insert blocks lookup.
  logic ins_fire;
  logic lkp_fire;
  assign ins_ready_o = !flush_i;
  assign lkp_ready_o = !flush_i && !ins_valid_i && (!rsp_valid_o || rsp_ready_i);
  assign ins_fire    = ins_valid_i && ins_ready_o;
  assign lkp_fire    = lkp_valid_i && lkp_ready_o;

  // Victim search
  logic          vict_found;
  logic [IW-1:0] vict_idx;
  logic [IW-1:0] fill_idx;

  fa_tlb_prio #(.N(ENTRIES)) u_victim (
    .req_i   (~valid_q | ~used_q),
    .found_o (vict_found),
    .idx_o   (vict_idx)
  );

  always_comb begin
    if (ins_use_idx_i)
      fill_idx = ins_idx_i;
    else if (vict_found)
      fill_idx = vict_idx;
    else
      fill_idx = IW'(ENTRIES - 1);
  end

  // Lookup compare and hit selection
  logic [ENTRIES-1:0] hit_vec;
  logic               lkp_hit;
  logic [IW-1:0]      hit_idx;

  fa_tlb_match #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .PID_W   (PID_W),
    .CTX_W   (CTX_W)
  ) u_match (
    .valid_i   (valid_q),
    .tag_i     (tag_q),
    .pid_i     (pid_q),
    .ctx_i     (ctx_q),
    .rmode_i   (rmode_q),
    .size_i    (size_q),
    .va_i      (lkp_va_i),
    .pid_q_i   (lkp_pid_i),
    .ctx_q_i   (lkp_ctx_i),
    .rmode_q_i (lkp_rmode_i),
    .hit_o     (hit_vec)
  );

  fa_tlb_prio #(.N(ENTRIES)) u_hitsel (
    .req_i   (hit_vec),
    .found_o (lkp_hit),
    .idx_o   (hit_idx)
  );

  // Used-bit policy
  logic [ENTRIES-1:0] used_nxt;

  fa_tlb_used #(.N(ENTRIES)) u_used (
    .used_i (used_q),
    .hit_i  (lkp_fire && lkp_hit),
    .idx_i  (hit_idx),
    .used_o (used_nxt)
  );

  // Address merge: page base from the slot, offset from the request
  logic [PA_W-1:0] off_mask;
  logic [PA_W-1:0] pa_merge;

  always_comb begin
    off_mask = (PA_W'(1) << pg_shift(pg_size_e'(size_q[hit_idx]))) - PA_W'(1);
    if (lkp_hit)
      pa_merge = (pa_q[hit_idx] & ~off_mask) | (lkp_va_i[PA_W-1:0] & off_mask);
    else
      pa_merge = '0;
  end

  // Control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      used_q  <= '0;
    end else if (ins_fire) begin
      valid_q[fill_idx] <= 1'b1;
      used_q[fill_idx]  <= ins_use_idx_i;
    end else if (lkp_fire) begin
      used_q <= used_nxt;
    end
  end

  // Payload (no reset needed; guarded by valid_q)
  always_ff @(posedge clk) begin
    if (ins_fire) begin
      tag_q[fill_idx]   <= ins_va_i;
      pid_q[fill_idx]   <= ins_pid_i;
      ctx_q[fill_idx]   <= ins_ctx_i;
      rmode_q[fill_idx] <= ins_rmode_i;
      size_q[fill_idx]  <= ins_size_i;
      pa_q[fill_idx]    <= ins_pa_i;
    end
  end

  // One-deep response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_pa_o    <= '0;
    end else if (lkp_fire) begin
      rsp_valid_o <= 1'b1;
      rsp_hit_o   <= lkp_hit;
      rsp_pa_o    <= pa_merge;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fa_tlb_checker.sv
`timescale 1ns/1ps
module fa_tlb_checker #(
  parameter int ENTRIES = 8,
  parameter int IW      = 3,
  parameter int PA_W    = 36
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               ins_valid_i,
  input logic               ins_ready_o,
  input logic               ins_use_idx_i,
  input logic [IW-1:0]      ins_idx_i,
  input logic               lkp_valid_i,
  input logic               lkp_ready_o,
  input logic               rsp_valid_o,
  input logic               rsp_ready_i,
  input logic               rsp_hit_o,
  input logic [PA_W-1:0]    rsp_pa_o,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] used_q
);
  assert_flush_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!ins_ready_o && !lkp_ready_o));

  assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));

  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && ins_use_idx_i) |-> (32'(ins_idx_i) < ENTRIES));

  assert_miss_pa_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_pa_o == '0));

  assert_used_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid_i && lkp_ready_o && !(&used_q)) |=> !(&used_q));

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid_i && lkp_ready_o) |=> rsp_valid_o);

  assert_insert_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_i |-> !lkp_ready_o);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_hit_o) && $stable(rsp_pa_o)));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid_i && !lkp_ready_o) |=> lkp_valid_i);
endmodule

bind fa_tlb fa_tlb_checker #(
  .ENTRIES (ENTRIES),
  .IW      (IW),
  .PA_W    (PA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_i       (flush_i),
  .ins_valid_i   (ins_valid_i),
  .ins_ready_o   (ins_ready_o),
  .ins_use_idx_i (ins_use_idx_i),
  .ins_idx_i     (ins_idx_i),
  .lkp_valid_i   (lkp_valid_i),
  .lkp_ready_o   (lkp_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ready_i   (rsp_ready_i),
  .rsp_hit_o     (rsp_hit_o),
  .rsp_pa_o      (rsp_pa_o),
  .valid_q       (valid_q),
  .used_q        (used_q)
);

// File: tb/fa_tlb_test.sv
`timescale 1ns/1ps
module fa_tlb_test;
  localparam int N = 8;
  localparam int VW = 40;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0;
  logic ins_valid_i = 1'b0, ins_use_idx_i = 1'b0, ins_rmode_i = 1'b0;
  logic [2:0] ins_idx_i = '0;
  logic [VW-1:0] ins_va_i = '0;
  logic [2:0] ins_pid_i = '0;
  logic [12:0] ins_ctx_i = '0;
  logic [1:0] ins_size_i = '0;
  logic [PW-1:0] ins_pa_i = '0;
  logic lkp_valid_i = 1'b0, lkp_rmode_i = 1'b0, rsp_ready_i = 1'b1;
  logic [VW-1:0] lkp_va_i = '0;
  logic [2:0] lkp_pid_i = '0;
  logic [12:0] lkp_ctx_i = '0;
  logic ins_ready_o, lkp_ready_o, rsp_valid_o, rsp_hit_o;
  logic [PW-1:0] rsp_pa_o;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fa_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .ins_valid_i(ins_valid_i), .ins_ready_o(ins_ready_o),
    .ins_use_idx_i(ins_use_idx_i), .ins_idx_i(ins_idx_i),
    .ins_va_i(ins_va_i), .ins_pid_i(ins_pid_i), .ins_ctx_i(ins_ctx_i),
    .ins_rmode_i(ins_rmode_i), .ins_size_i(ins_size_i), .ins_pa_i(ins_pa_i),
    .lkp_valid_i(lkp_valid_i), .lkp_ready_o(lkp_ready_o),
    .lkp_va_i(lkp_va_i), .lkp_pid_i(lkp_pid_i), .lkp_ctx_i(lkp_ctx_i),
    .lkp_rmode_i(lkp_rmode_i), .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i), .rsp_hit_o(rsp_hit_o), .rsp_pa_o(rsp_pa_o)
  );

  // Reference table
  logic          m_valid [N];
  logic          m_used  [N];
  logic [VW-1:0] m_va    [N];
  logic [2:0]    m_pid   [N];
  logic [12:0]   m_ctx   [N];
  logic          m_rm    [N];
  logic [1:0]    m_sz    [N];
  logic [PW-1:0] m_pa    [N];

  function automatic int shift_of(logic [1:0] s);
    case (s)
      2'd0: return 13;
      2'd1: return 16;
      2'd2: return 22;
      default: return 28;
    endcase
  endfunction

  function automatic int m_find(logic [VW-1:0] va, logic [2:0] pid, logic [12:0] ctx, logic rm);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_pid[i] == pid && m_ctx[i] == ctx && m_rm[i] == rm &&
          ((va ^ m_va[i]) >> shift_of(m_sz[i])) == '0)
        return i;
    return -1;
  endfunction

  function automatic logic [PW-1:0] m_pa_of(int i, logic [VW-1:0] va);
    logic [PW-1:0] msk = (PW'(1) << shift_of(m_sz[i])) - PW'(1);
    return (m_pa[i] & ~msk) | (va[PW-1:0] & msk);
  endfunction

  function automatic void m_clear();
    for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_used[i] = 1'b0; end
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_insert(input int slot, input logic [VW-1:0] va, input logic [2:0] pid,
                           input logic [12:0] ctx, input logic rm, input logic [1:0] sz,
                           input logic [PW-1:0] pa);
    int tgt = -1;
    @(negedge clk);
    ins_valid_i = 1'b1; ins_use_idx_i = (slot >= 0); ins_idx_i = 3'(slot < 0 ? 0 : slot);
    ins_va_i = va; ins_pid_i = pid; ins_ctx_i = ctx; ins_rmode_i = rm; ins_size_i = sz; ins_pa_i = pa;
    @(negedge clk);
    ins_valid_i = 1'b0;
    if (slot >= 0) tgt = slot;
    else begin
      for (int i = 0; i < N; i++) if (tgt < 0 && (!m_valid[i] || !m_used[i])) tgt = i;
      if (tgt < 0) tgt = N - 1;
    end
    m_valid[tgt] = 1'b1; m_used[tgt] = (slot >= 0);
    m_va[tgt] = va; m_pid[tgt] = pid; m_ctx[tgt] = ctx; m_rm[tgt] = rm; m_sz[tgt] = sz; m_pa[tgt] = pa;
  endtask

  function automatic void m_touch(int h);
    bit all;
    if (h < 0 || m_used[h]) return;
    m_used[h] = 1'b1;
    all = 1'b1;
    for (int i = 0; i < N; i++) all &= m_used[i];
    if (all) for (int i = 0; i < N; i++) m_used[i] = (i == h);
  endfunction

  // Drive lookup, wait for acceptance, check response one edge later.
  task automatic do_lookup(input logic [VW-1:0] va, input logic [2:0] pid, input logic [12:0] ctx,
                           input logic rm, input string req);
    int h;
    logic [PW-1:0] exp_pa;
    @(negedge clk);
    lkp_valid_i = 1'b1; lkp_va_i = va; lkp_pid_i = pid; lkp_ctx_i = ctx; lkp_rmode_i = rm;
    while (!lkp_ready_o) @(negedge clk);
    @(negedge clk);
    lkp_valid_i = 1'b0;
    h = m_find(va, pid, ctx, rm);
    exp_pa = (h >= 0) ? m_pa_of(h, va) : '0;
    check(rsp_valid_o && rsp_hit_o == (h >= 0) && rsp_pa_o == exp_pa, req,
          {27'd0, rsp_hit_o, rsp_pa_o}, {27'd0, (h >= 0), exp_pa});
    m_touch(h);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    #1;
    check(!ins_ready_o && !lkp_ready_o, "R1 flush ready", {ins_ready_o, lkp_ready_o}, 0);
    @(negedge clk);
    flush_i = 1'b0;
    m_clear();
  endtask

  function automatic logic [VW-1:0] rnd_va();
    return (VW'($urandom % 4) << 28) | (VW'($urandom % 4) << 22) |
           (VW'($urandom % 4) << 16) | VW'($urandom % 8192);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    void'($urandom(32'd20240611));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid_o && ins_ready_o && lkp_ready_o, "R1 reset state",
          {rsp_valid_o, ins_ready_o, lkp_ready_o}, 3'b011);
    do_lookup(40'h0, 0, 0, 0, "R1 lookup after reset misses");

    // R3 auto fill of empty table, R9 next-cycle visibility, R7 merge
    for (int i = 0; i < N; i++)
      do_insert(-1, 40'(i) << 28, 3'd1, 13'd5, 1'b0, 2'd0, PW'(36'h100000 * (i + 1)));
    for (int i = 0; i < N; i++)
      do_lookup((40'(i) << 28) | 40'h1abc, 3'd1, 13'd5, 1'b0, "R3 R7 R9 auto fill hit");

    // R8 saturation: all hit once, last hit clears the others; next auto fill lands in slot 0
    do_insert(-1, 40'h55 << 28, 3'd1, 13'd5, 1'b0, 2'd0, 36'hABC000);
    do_lookup(40'h0, 3'd1, 13'd5, 1'b0, "R3 R8 slot 0 replaced misses");
    do_lookup(40'h55 << 28, 3'd1, 13'd5, 1'b0, "R8 new entry hits");
    do_lookup(40'h7 << 28, 3'd1, 13'd5, 1'b0, "R8 slot 7 kept");

    // R5 identifier mismatches
    do_lookup(40'h3 << 28, 3'd2, 13'd5, 1'b0, "R5 partition mismatch");
    do_lookup(40'h3 << 28, 3'd1, 13'd6, 1'b0, "R5 context mismatch");
    do_lookup(40'h3 << 28, 3'd1, 13'd5, 1'b1, "R5 real flag mismatch");

    // R2 explicit fill of every slot (used set), then R4 fallback to last slot
    do_flush();
    do_lookup(40'h3 << 28, 3'd1, 13'd5, 1'b0, "R1 flush empties");
    for (int i = 0; i < N; i++)
      do_insert(i, 40'(i + 16) << 28, 3'd0, 13'd9, 1'b1, 2'd1, PW'(36'h20000 * (i + 1)));
    do_insert(-1, 40'h77 << 28, 3'd0, 13'd9, 1'b1, 2'd1, 36'hFFF0000);
    do_lookup(40'd23 << 28, 3'd0, 13'd9, 1'b1, "R4 last slot overwritten");
    do_lookup(40'h77 << 28, 3'd0, 13'd9, 1'b1, "R4 new entry in last slot");
    do_lookup(40'd22 << 28, 3'd0, 13'd9, 1'b1, "R4 slot 6 kept");
    do_insert(2, 40'h99 << 28, 3'd0, 13'd9, 1'b1, 2'd2, 36'h3C00000);
    do_lookup(40'd18 << 28, 3'd0, 13'd9, 1'b1, "R2 named slot replaced");
    do_lookup((40'h99 << 28) | 40'h3FFFFF, 3'd0, 13'd9, 1'b1, "R2 R6 named entry 4M hits");

    // R6 page-size masking, R7 lowest index wins
    do_flush();
    do_insert(-1, 40'h5 << 28, 3'd3, 13'd1, 1'b0, 2'd3, 36'hA0000000);
    do_lookup((40'h5 << 28) | (40'd1 << 27), 3'd3, 13'd1, 1'b0, "R6 256M offset bit ignored");
    do_lookup((40'h5 << 28) ^ (40'd1 << 28), 3'd3, 13'd1, 1'b0, "R6 256M tag bit compared");
    do_insert(-1, 40'h1230000, 3'd3, 13'd1, 1'b0, 2'd1, 36'h7770000);
    do_lookup(40'h123FFFF, 3'd3, 13'd1, 1'b0, "R6 R7 64K offset merge");
    do_lookup(40'h1240000, 3'd3, 13'd1, 1'b0, "R6 64K tag bit");
    do_insert(5, 40'h6 << 28, 3'd3, 13'd1, 1'b0, 2'd0, 36'h1111000);
    do_insert(4, 40'h6 << 28, 3'd3, 13'd1, 1'b0, 2'd0, 36'h2222000);
    do_lookup((40'h6 << 28) | 40'h10, 3'd3, 13'd1, 1'b0, "R7 lowest slot wins");

    // R10 insert precedence and R9 visibility in the next cycle
    @(negedge clk);
    ins_valid_i = 1'b1; ins_use_idx_i = 1'b0; ins_va_i = 40'h9 << 28; ins_pid_i = 3'd3;
    ins_ctx_i = 13'd1; ins_rmode_i = 1'b0; ins_size_i = 2'd0; ins_pa_i = 36'h9990000;
    lkp_valid_i = 1'b1; lkp_va_i = 40'h9 << 28; lkp_pid_i = 3'd3; lkp_ctx_i = 13'd1; lkp_rmode_i = 1'b0;
    #1;
    check(!lkp_ready_o, "R10 insert blocks lookup", lkp_ready_o, 0);
    lkp_valid_i = 1'b0;
    @(negedge clk);
    ins_valid_i = 1'b0;
    for (int i = 0; i < N; i++)
      if (!m_valid[i] || !m_used[i]) begin
        m_valid[i] = 1'b1; m_used[i] = 1'b0; m_va[i] = 40'h9 << 28; m_pid[i] = 3'd3;
        m_ctx[i] = 13'd1; m_rm[i] = 1'b0; m_sz[i] = 2'd0; m_pa[i] = 36'h9990000;
        break;
      end
    do_lookup(40'h9 << 28, 3'd3, 13'd1, 1'b0, "R9 insert visible next cycle");

    // R10 back-pressure
    @(negedge clk);
    rsp_ready_i = 1'b0;
    lkp_valid_i = 1'b1; lkp_va_i = 40'h9 << 28;
    @(negedge clk);
    lkp_valid_i = 1'b0;
    held = rsp_pa_o;
    check(rsp_valid_o && rsp_hit_o && rsp_pa_o == 36'h9990000, "R10 response captured",
          rsp_pa_o, 36'h9990000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid_o && rsp_pa_o == held && !lkp_ready_o, "R10 response held",
            {rsp_valid_o, lkp_ready_o}, 2'b10);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk);
    check(!rsp_valid_o, "R10 response drained", rsp_valid_o, 0);

    // Constrained random mix
    do_flush();
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 10;
      if (op < 3) begin
        int sl = ($urandom % 4 == 0) ? int'($urandom % N) : -1;
        do_insert(sl, rnd_va(), 3'($urandom % 2), 13'($urandom % 3), 1'($urandom % 2),
                  2'($urandom % 4), PW'({$urandom, $urandom}));
      end else if (op < 9) begin
        int j = $urandom % N;
        if (m_valid[j] && ($urandom % 3 != 0)) begin
          logic [VW-1:0] msk = (VW'(1) << shift_of(m_sz[j])) - VW'(1);
          logic [VW-1:0] v = (m_va[j] & ~msk) | (VW'({$urandom, $urandom}) & msk);
          do_lookup(v, m_pid[j], m_ctx[j], m_rm[j], "R5 R6 R7 R8 random hit path");
        end else begin
          do_lookup(rnd_va(), 3'($urandom % 2), 13'($urandom % 3), 1'($urandom % 2),
                    "R5 random lookup");
        end
      end else if ($urandom % 6 == 0) begin
        do_flush();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule